// File: doc/BRIEF.md
# Byte-Wide Message Mailbox

This block is a two-way mailbox between an 8-bit host register bus and on-chip logic. It holds two message buffers, one per direction, and each buffer holds up to `DEPTH` bytes (16 by default). The host builds an inbound message one byte at a time through a data port. It then writes a byte count, and that write hands the message to the core. Before it starts a new message, the host watches an empty flag. The core takes the message as a valid/ready byte stream that marks the final byte.

In the other direction, the core appends bytes to the outbound buffer and then posts them with a load strobe that carries a length. The host reads a read-only count, then reads the outbound data port once per byte. The count falls by one with each byte read. A new post is refused until the host has read the previous message to the end.

The four host registers sit at offsets 0 to 3. A two-stage synchronizer inside the block releases the asynchronous reset.

Top module: `msgbox_top`

## Requirements
- R1: After reset, all four registers read 0x00, `in_empty` is 1, `in_len_err` is 0, `core_in_valid` is 0 and `core_out_busy` is 0.
- R2: Register offsets are fixed.
  - 0 is the inbound count. It reads back the last accepted count after saturation.
  - 1 is the outbound remaining count.
  - 2 is the outbound data port.
  - 3 is the inbound data port. It reads back the last byte written to it.
  - Both count registers hold the count in bits [4:0] and read zeros in bits [7:5]. Bits [7:5] of a count write are ignored.
- R3: Writes to offset 3 while `in_empty` is 1 store bytes in order. Once `DEPTH` bytes are held, further data writes are ignored.
- R4: A nonzero count written to offset 0 while `in_empty` is 1 commits the message. On the next cycle, `in_empty` is 0 and `core_in_valid` is 1. The core then receives bytes 0 through count-1 in write order, and `core_in_last` is high on the final byte.
- R5: A committed count above `DEPTH` is saturated to `DEPTH` and sets `in_len_err`. That flag stays set until reset.
- R6: While `in_empty` is 0, host data writes and count writes are ignored. Neither the delivered bytes nor the offset-0 readback change.
- R7: `in_empty` returns to 1 in the cycle after the final byte's handshake. Committing a count of 0 leaves `in_empty` at 1 and produces no stream.
- R8: A load strobe is accepted only while `core_out_busy` is 0, and it sets the outbound count to the load length, saturated at `DEPTH`. Each read of offset 2 returns the next byte in fill order and lowers the count by one. `core_out_busy` is 1 whenever the count is nonzero.
- R9: Reading offset 2 with a count of 0 returns 0x00 and changes nothing.
- R10: Fill bytes and load strobes that arrive while `core_out_busy` is 1 are ignored.
- R11: While `core_in_valid` is 1 and `core_in_ready` is 0, the byte and the valid flag hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr_en | input | 1 | Host write strobe |
| host_rd_en | input | 1 | Host read strobe; a read of offset 2 advances the outbound pointer |
| host_addr | input | 2 | Register offset |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data, valid in the cycle of `host_rd_en`; 0 otherwise |
| in_empty | output | 1 | Inbound buffer is free for loading |
| in_len_err | output | 1 | Sticky flag for an oversized committed count |
| core_in_valid | output | 1 | Inbound byte available |
| core_in_ready | input | 1 | Core accepts the inbound byte |
| core_in_data | output | 8 | Inbound byte |
| core_in_last | output | 1 | Current inbound byte is the final one |
| core_out_fill_en | input | 1 | Append a byte to the outbound buffer |
| core_out_fill_data | input | 8 | Byte to append |
| core_out_load | input | 1 | Post the filled bytes as a message |
| core_out_len | input | 5 | Length of the posted message |
| core_out_busy | output | 1 | Outbound message still being read |

## Verification
The bench builds the block with `DEPTH` = 16 and two synchronizer stages. With these values the 5-bit count field can carry values from 17 to 31, so it can drive both saturation paths. A 20-byte load can also run past the buffer end, and reads can go past an exhausted message.

A behavioural queue model is compared with every output on each cycle. The inbound stream is checked under a ready pattern that stalls every third cycle. Literal expected values back up the model at the length, saturation and exhaustion boundaries.

// File: rtl/msgbox_pkg.sv
package msgbox_pkg;
  localparam int DATA_W  = 8;
  localparam int FIELD_W = 5;

  typedef enum logic [1:0] {
    OFS_IN_CNT   = 2'd0,
    OFS_OUT_CNT  = 2'd1,
    OFS_OUT_PORT = 2'd2,
    OFS_IN_PORT  = 2'd3
  } mb_ofs_e;
endpackage

// File: rtl/msgbox_rst_sync.sv
module msgbox_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  generate
    if (STAGES < 2) begin : g_single
      logic q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= 1'b0;
        else        q <= 1'b1;
      end
      assign srst_n = q;
    end else begin : g_chain
      logic [STAGES-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= {q[STAGES-2:0], 1'b1};
      end
      assign srst_n = q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/msgbox_decode.sv
module msgbox_decode
  import msgbox_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [1:0]         addr,
  input  logic [DATA_W-1:0]  wdata,
  input  logic [FIELD_W-1:0] in_cnt,
  input  logic [FIELD_W-1:0] out_cnt,
  input  logic [DATA_W-1:0]  out_byte,
  output logic               in_data_we,
  output logic               in_cnt_we,
  output logic               out_data_re,
  output logic [DATA_W-1:0]  rdata
);
  localparam int PAD_W = DATA_W - FIELD_W;

  mb_ofs_e           ofs;
  logic [DATA_W-1:0] port_q, port_d;
  logic              port_en;

  assign ofs = mb_ofs_e'(addr);

  always_comb begin
    in_data_we  = wr_en && (ofs == OFS_IN_PORT);
    in_cnt_we   = wr_en && (ofs == OFS_IN_CNT);
    out_data_re = rd_en && (ofs == OFS_OUT_PORT);
    port_en     = in_data_we;
    port_d      = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       port_q <= '0;
    else if (port_en) port_q <= port_d;
  end

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      unique case (ofs)
        OFS_IN_CNT:   rdata = {{PAD_W{1'b0}}, in_cnt};
        OFS_OUT_CNT:  rdata = {{PAD_W{1'b0}}, out_cnt};
        OFS_OUT_PORT: rdata = out_byte;
        OFS_IN_PORT:  rdata = port_q;
      endcase
    end
  end
endmodule

// File: rtl/msgbox_in_buf.sv
module msgbox_in_buf
  import msgbox_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic               commit_en,
  input  logic [FIELD_W-1:0] commit_val,
  output logic               empty,
  output logic [FIELD_W-1:0] cnt_reg,
  output logic               err,
  output logic               valid,
  input  logic               ready,
  output logic [DATA_W-1:0]  data,
  output logic               last
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [FIELD_W-1:0] DEPTH_F = FIELD_W'(DEPTH);
  localparam logic [FIELD_W-1:0] ONE_F   = FIELD_W'(1);

  logic [DATA_W-1:0]  mem [DEPTH];
  logic               empty_q, empty_d;
  logic               err_q, err_d;
  logic [FIELD_W-1:0] wcnt_q, wcnt_d;
  logic [FIELD_W-1:0] rcnt_q, rcnt_d;
  logic [FIELD_W-1:0] clen_q, clen_d;
  logic [FIELD_W-1:0] creg_q, creg_d;
  logic               mem_we, hs, fin, take_commit, over;
  logic [FIELD_W-1:0] sat_val;
  logic               st_en;

  always_comb begin
    over        = commit_val > DEPTH_F;
    sat_val     = over ? DEPTH_F : commit_val;
    take_commit = commit_en && empty_q;
    mem_we      = wr_en && empty_q && (wcnt_q < DEPTH_F);
    hs          = !empty_q && ready;
    fin         = hs && (rcnt_q == clen_q - ONE_F);
  end

  always_comb begin
    empty_d = empty_q;
    err_d   = err_q;
    wcnt_d  = wcnt_q;
    rcnt_d  = rcnt_q;
    clen_d  = clen_q;
    creg_d  = creg_q;
    if (mem_we) wcnt_d = wcnt_q + ONE_F;
    if (take_commit) begin
      creg_d = sat_val;
      if (over) err_d = 1'b1;
      if (sat_val != '0) begin
        empty_d = 1'b0;
        clen_d  = sat_val;
        rcnt_d  = '0;
      end else begin
        wcnt_d  = '0;
      end
    end
    if (hs) begin
      rcnt_d = rcnt_q + ONE_F;
      if (fin) begin
        empty_d = 1'b1;
        wcnt_d  = '0;
      end
    end
  end

  assign st_en = mem_we || take_commit || hs;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      empty_q <= 1'b1;
      err_q   <= 1'b0;
      wcnt_q  <= '0;
      rcnt_q  <= '0;
      clen_q  <= '0;
      creg_q  <= '0;
    end else if (st_en) begin
      empty_q <= empty_d;
      err_q   <= err_d;
      wcnt_q  <= wcnt_d;
      rcnt_q  <= rcnt_d;
      clen_q  <= clen_d;
      creg_q  <= creg_d;
    end
  end

  always_ff @(posedge clk) begin
    if (mem_we) mem[wcnt_q[PTR_W-1:0]] <= wr_data;
  end

  assign empty   = empty_q;
  assign err     = err_q;
  assign cnt_reg = creg_q;
  assign valid   = !empty_q;
  assign data    = empty_q ? '0 : mem[rcnt_q[PTR_W-1:0]];
  assign last    = !empty_q && (rcnt_q == clen_q - ONE_F);
endmodule

// File: rtl/msgbox_out_buf.sv
module msgbox_out_buf
  import msgbox_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fill_en,
  input  logic [DATA_W-1:0]  fill_data,
  input  logic               load_en,
  input  logic [FIELD_W-1:0] load_len,
  input  logic               rd_en,
  output logic [FIELD_W-1:0] remain,
  output logic [DATA_W-1:0]  rd_byte,
  output logic               busy
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [FIELD_W-1:0] DEPTH_F = FIELD_W'(DEPTH);
  localparam logic [FIELD_W-1:0] ONE_F   = FIELD_W'(1);

  logic [DATA_W-1:0]  mem [DEPTH];
  logic [FIELD_W-1:0] left_q, left_d;
  logic [FIELD_W-1:0] rptr_q, rptr_d;
  logic [FIELD_W-1:0] fcnt_q, fcnt_d;
  logic               idle, mem_we, take_load, take_rd, st_en;

  always_comb begin
    idle      = (left_q == '0);
    take_load = load_en && idle;
    mem_we    = fill_en && idle && !load_en && (fcnt_q < DEPTH_F);
    take_rd   = rd_en && !idle;
  end

  always_comb begin
    left_d = left_q;
    rptr_d = rptr_q;
    fcnt_d = fcnt_q;
    if (mem_we) fcnt_d = fcnt_q + ONE_F;
    if (take_load) begin
      left_d = (load_len > DEPTH_F) ? DEPTH_F : load_len;
      rptr_d = '0;
      fcnt_d = '0;
    end
    if (take_rd) begin
      left_d = left_q - ONE_F;
      rptr_d = rptr_q + ONE_F;
    end
  end

  assign st_en = mem_we || take_load || take_rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q <= '0;
      rptr_q <= '0;
      fcnt_q <= '0;
    end else if (st_en) begin
      left_q <= left_d;
      rptr_q <= rptr_d;
      fcnt_q <= fcnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (mem_we) mem[fcnt_q[PTR_W-1:0]] <= fill_data;
  end

  assign remain  = left_q;
  assign busy    = !idle;
  assign rd_byte = idle ? '0 : mem[rptr_q[PTR_W-1:0]];
endmodule

// File: rtl/msgbox_top.sv
module msgbox_top
  import msgbox_pkg::*;
#(
  parameter int DEPTH      = 16,
  parameter int SYNC_STAGE = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_wr_en,
  input  logic               host_rd_en,
  input  logic [1:0]         host_addr,
  input  logic [DATA_W-1:0]  host_wdata,
  output logic [DATA_W-1:0]  host_rdata,
  output logic               in_empty,
  output logic               in_len_err,
  output logic               core_in_valid,
  input  logic               core_in_ready,
  output logic [DATA_W-1:0]  core_in_data,
  output logic               core_in_last,
  input  logic               core_out_fill_en,
  input  logic [DATA_W-1:0]  core_out_fill_data,
  input  logic               core_out_load,
  input  logic [FIELD_W-1:0] core_out_len,
  output logic               core_out_busy
);
  logic               srst_n;
  logic               in_data_we, in_cnt_we, out_data_re;
  logic [FIELD_W-1:0] in_cnt_w, out_len_w;
  logic [DATA_W-1:0]  out_byte_w;

  msgbox_rst_sync #(.STAGES(SYNC_STAGE)) u_rst (
    .clk(clk), .rst_n(rst_n), .srst_n(srst_n)
  );

  msgbox_decode u_dec (
    .clk(clk), .rst_n(srst_n),
    .wr_en(host_wr_en), .rd_en(host_rd_en), .addr(host_addr), .wdata(host_wdata),
    .in_cnt(in_cnt_w), .out_cnt(out_len_w), .out_byte(out_byte_w),
    .in_data_we(in_data_we), .in_cnt_we(in_cnt_we), .out_data_re(out_data_re),
    .rdata(host_rdata)
  );

  msgbox_in_buf #(.DEPTH(DEPTH)) u_in (
    .clk(clk), .rst_n(srst_n),
    .wr_en(in_data_we), .wr_data(host_wdata),
    .commit_en(in_cnt_we), .commit_val(host_wdata[FIELD_W-1:0]),
    .empty(in_empty), .cnt_reg(in_cnt_w), .err(in_len_err),
    .valid(core_in_valid), .ready(core_in_ready),
    .data(core_in_data), .last(core_in_last)
  );

  msgbox_out_buf #(.DEPTH(DEPTH)) u_out (
    .clk(clk), .rst_n(srst_n),
    .fill_en(core_out_fill_en), .fill_data(core_out_fill_data),
    .load_en(core_out_load), .load_len(core_out_len),
    .rd_en(out_data_re),
    .remain(out_len_w), .rd_byte(out_byte_w), .busy(core_out_busy)
  );
endmodule

// File: rtl/msgbox_chk.sv
module msgbox_chk
  import msgbox_pkg::*;
(
  input logic               clk,
  input logic               srst_n,
  input logic               host_rd_en,
  input logic [1:0]         host_addr,
  input logic [DATA_W-1:0]  host_rdata,
  input logic               in_empty,
  input logic               in_len_err,
  input logic               core_in_valid,
  input logic               core_in_ready,
  input logic [DATA_W-1:0]  core_in_data,
  input logic               core_in_last,
  input logic [FIELD_W-1:0] out_len,
  input logic               core_out_busy
);
  // R2: count registers never show bits above the field
  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!srst_n)
    (host_rd_en && host_addr[1] == 1'b0) |-> (host_rdata[7:5] == 3'b000));

  // R4: the stream is offered only while the inbound buffer holds a message
  a_r4_valid_only_full: assert property (@(posedge clk) disable iff (!srst_n)
    core_in_valid |-> !in_empty);

  // R5: the oversize flag never drops once raised
  a_r5_err_sticky: assert property (@(posedge clk) disable iff (!srst_n)
    in_len_err |=> in_len_err);

  // R6: a held message is released only by its final handshake
  a_r6_hold_full: assert property (@(posedge clk) disable iff (!srst_n)
    (!in_empty && !(core_in_valid && core_in_ready && core_in_last)) |=> !in_empty);

  // R7: the buffer frees after the final byte is taken
  a_r7_free_after_last: assert property (@(posedge clk) disable iff (!srst_n)
    (core_in_valid && core_in_ready && core_in_last) |=> in_empty);

  // R8: each data read lowers the outbound count by one
  a_r8_countdown: assert property (@(posedge clk) disable iff (!srst_n)
    (host_rd_en && host_addr == 2'd2 && out_len != '0) |=> (out_len == $past(out_len) - 5'd1));

  // R8: busy reports a nonzero count
  a_r8_busy_len: assert property (@(posedge clk) disable iff (!srst_n)
    core_out_busy |-> (out_len != '0));

  // R9: an exhausted data port reads zero
  a_r9_exhausted_zero: assert property (@(posedge clk) disable iff (!srst_n)
    (host_rd_en && host_addr == 2'd2 && out_len == '0) |-> (host_rdata == 8'h00));

  // R11: a stalled byte stays put
  a_r11_stall_stable: assert property (@(posedge clk) disable iff (!srst_n)
    (core_in_valid && !core_in_ready) |=> (core_in_valid && $stable(core_in_data) && $stable(core_in_last)));
endmodule

bind msgbox_top msgbox_chk u_chk (
  .clk(clk), .srst_n(srst_n),
  .host_rd_en(host_rd_en), .host_addr(host_addr), .host_rdata(host_rdata),
  .in_empty(in_empty), .in_len_err(in_len_err),
  .core_in_valid(core_in_valid), .core_in_ready(core_in_ready),
  .core_in_data(core_in_data), .core_in_last(core_in_last),
  .out_len(out_len_w), .core_out_busy(core_out_busy)
);

// File: tb/msgbox_top_tb_top.sv
`timescale 1ns/1ps
module msgbox_top_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       host_wr_en = 0, host_rd_en = 0;
  logic [1:0] host_addr = 0;
  logic [7:0] host_wdata = 0;
  logic [7:0] host_rdata;
  logic       in_empty, in_len_err, core_in_valid, core_in_last, core_out_busy;
  logic       core_in_ready = 0;
  logic [7:0] core_in_data;
  logic       core_out_fill_en = 0, core_out_load = 0;
  logic [7:0] core_out_fill_data = 0;
  logic [4:0] core_out_len = 0;

  int checks = 0, errors = 0, cycles = 0;
  bit started = 0;

  always #2 clk = ~clk;

  msgbox_top dut_i (
    .clk(clk), .rst_n(rst_n),
    .host_wr_en(host_wr_en), .host_rd_en(host_rd_en), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .in_empty(in_empty), .in_len_err(in_len_err),
    .core_in_valid(core_in_valid), .core_in_ready(core_in_ready),
    .core_in_data(core_in_data), .core_in_last(core_in_last),
    .core_out_fill_en(core_out_fill_en), .core_out_fill_data(core_out_fill_data),
    .core_out_load(core_out_load), .core_out_len(core_out_len),
    .core_out_busy(core_out_busy)
  );

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- reference model ----------------
  byte unsigned m_fill[$];
  byte unsigned m_ofill[$];
  byte unsigned m_oq[$];
  bit m_busy, m_err, b0, ob0;
  int m_pos, m_clen, m_cnt, v, n;
  byte unsigned m_port;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_fill.delete(); m_ofill.delete(); m_oq.delete();
      m_busy = 0; m_err = 0; m_pos = 0; m_clen = 0; m_cnt = 0; m_port = 0;
    end else begin
      b0  = m_busy;
      ob0 = (m_oq.size() != 0);
      if (b0 && core_in_ready) begin
        m_pos++;
        if (m_pos == m_clen) begin m_busy = 0; m_fill.delete(); end
      end
      if (host_wr_en && host_addr == 2'd3) begin
        m_port = host_wdata;
        if (!b0 && m_fill.size() < 16) m_fill.push_back(host_wdata);
      end
      if (host_wr_en && host_addr == 2'd0 && !b0) begin
        v = int'(host_wdata[4:0]);
        if (v > 16) begin v = 16; m_err = 1; end
        m_cnt = v;
        if (v != 0) begin m_busy = 1; m_pos = 0; m_clen = v; end
        else m_fill.delete();
      end
      if (host_rd_en && host_addr == 2'd2 && ob0) void'(m_oq.pop_front());
      if (core_out_load && !ob0) begin
        n = (core_out_len > 16) ? 16 : int'(core_out_len);
        m_oq.delete();
        for (int i = 0; i < n; i++) m_oq.push_back(m_ofill[i]);
        m_ofill.delete();
      end else if (core_out_fill_en && !ob0 && m_ofill.size() < 16)
        m_ofill.push_back(core_out_fill_data);
    end
  end

  function automatic int exp_rdata();
    case (host_addr)
      2'd0: return m_cnt;
      2'd1: return m_oq.size();
      2'd2: return (m_oq.size() != 0) ? int'(m_oq[0]) : 0;
      default: return int'(m_port);
    endcase
  endfunction

  // per-cycle comparison, 1 ns before the rising edge
  always @(negedge clk) begin
    #1;
    if (started) begin
      chk(in_empty, !m_busy, "R7 in_empty");
      chk(core_in_valid, m_busy, "R4 valid");
      chk(in_len_err, m_err, "R5 err");
      chk(core_out_busy, m_oq.size() != 0, "R8 busy");
      if (m_busy) begin
        chk(core_in_data, m_fill[m_pos], "R4 data");
        chk(core_in_last, m_pos == m_clen - 1, "R4 last");
      end
      if (host_rd_en) chk(host_rdata, exp_rdata(), "R2 rdata");
    end
  end

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected<=20000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  task automatic idle();
    @(negedge clk);
    host_wr_en = 0; host_rd_en = 0; core_out_fill_en = 0; core_out_load = 0;
  endtask

  task automatic hwr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    host_rd_en = 0; host_wr_en = 1; host_addr = a; host_wdata = d;
    core_out_fill_en = 0; core_out_load = 0;
  endtask

  task automatic hrd(input logic [1:0] a, input int exp, input string tag);
    @(negedge clk);
    host_wr_en = 0; host_rd_en = 1; host_addr = a;
    core_out_fill_en = 0; core_out_load = 0;
    #1 chk(host_rdata, exp, tag);
  endtask

  task automatic ofill(input logic [7:0] d);
    @(negedge clk);
    host_wr_en = 0; host_rd_en = 0; core_out_load = 0;
    core_out_fill_en = 1; core_out_fill_data = d;
  endtask

  task automatic oload(input logic [4:0] l);
    @(negedge clk);
    host_wr_en = 0; host_rd_en = 0; core_out_fill_en = 0;
    core_out_load = 1; core_out_len = l;
  endtask

  // drain with a stall every third cycle; collect accepted bytes
  task automatic drain(ref byte unsigned got[$]);
    got.delete();
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      host_wr_en = 0; host_rd_en = 0; core_out_fill_en = 0; core_out_load = 0;
      core_in_ready = (i % 3 != 2);
      #1;
      if (core_in_valid && core_in_ready) got.push_back(core_in_data);
      if (core_in_valid && core_in_ready && core_in_last) break;
    end
    @(negedge clk); core_in_ready = 0;
  endtask

  byte unsigned got[$];

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    started = 1;
    // R1: reset state
    hrd(2'd0, 0, "R1 in count"); hrd(2'd1, 0, "R1 out count");
    hrd(2'd2, 0, "R1 out port"); hrd(2'd3, 0, "R1 in port");
    #1 chk(in_empty, 1, "R1 empty");

    // R4: three-byte message, upper count bits ignored (R2)
    hwr(2'd3, 8'hA1); hwr(2'd3, 8'hA2); hwr(2'd3, 8'hA3);
    hwr(2'd0, 8'hE3);
    hrd(2'd0, 3, "R2 count readback masked");
    hrd(2'd3, 8'hA3, "R2 port readback");
    #1 chk(in_empty, 0, "R4 empty cleared");
    drain(got);
    chk(got.size(), 3, "R4 byte count");
    for (int i = 0; i < got.size() && i < 3; i++) chk(got[i], 8'hA1 + i, "R4 order");
    #1 chk(in_empty, 1, "R7 empty after last");

    // R3/R5: 20 bytes written, count 31 saturates
    for (int i = 0; i < 20; i++) hwr(2'd3, 8'h10 + i);
    hwr(2'd0, 8'h1F);
    hrd(2'd0, 16, "R5 saturated count");
    #1 chk(in_len_err, 1, "R5 err set");
    // R6: writes while full are ignored
    hwr(2'd3, 8'hEE); hwr(2'd0, 8'h02);
    hrd(2'd0, 16, "R6 count unchanged");
    drain(got);
    chk(got.size(), 16, "R3 byte count");
    for (int i = 0; i < got.size() && i < 16; i++) chk(got[i], 8'h10 + i, "R6 contents");
    #1 chk(in_len_err, 1, "R5 err sticky");

    // R7: zero count commits nothing
    hwr(2'd0, 8'h00); idle();
    #1 chk(in_empty, 1, "R7 zero commit"); chk(core_in_valid, 0, "R7 no stream");
    hrd(2'd0, 0, "R7 zero readback");

    // R8/R10/R9: outbound
    ofill(8'h11); ofill(8'h22); ofill(8'h33); ofill(8'h44); oload(5'd4);
    ofill(8'h99); oload(5'd2);
    hrd(2'd1, 4, "R10 load ignored while busy");
    hrd(2'd2, 8'h11, "R8 byte0"); hrd(2'd1, 3, "R8 countdown");
    hrd(2'd2, 8'h22, "R8 byte1"); hrd(2'd2, 8'h33, "R8 byte2"); hrd(2'd2, 8'h44, "R8 byte3");
    hrd(2'd1, 0, "R8 count zero");
    hrd(2'd2, 0, "R9 exhausted read"); hrd(2'd2, 0, "R9 exhausted again");
    hrd(2'd1, 0, "R9 count stays");
    #1 chk(core_out_busy, 0, "R8 idle");

    // R8: oversized load clamps
    for (int i = 0; i < 16; i++) ofill(8'h40 + i);
    oload(5'd20);
    hrd(2'd1, 16, "R8 clamp");
    for (int i = 0; i < 16; i++) hrd(2'd2, 8'h40 + i, "R8 long read");
    hrd(2'd2, 0, "R9 after long");
    idle(); idle();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule